// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block lets on-chip logic read and write 16-bit registers inside a PHY that is reachable only through a pair of words: a 20-bit control word driven by the block, and a 17-bit status word returned by the PHY. A request carries a read/write flag, a 16-bit register address and, for writes, 16 bits of data. The block breaks each request into a chain of four-phase strobe/acknowledge exchanges on the control word and reports the outcome with a one-cycle `done` pulse, an error flag and, for reads, the returned data.

Every exchange first latches the address in the PHY. A write then latches the data and issues a commit strobe. A read issues a read strobe and captures the data the PHY presents while it acknowledges. Each wait for the acknowledge bit to reach a level samples it a bounded number of times, at a fixed spacing given in clock cycles. If the level is not seen in time, the control word is cleared and the request ends with an error. The block is then idle and takes new requests.

Top module: `phy_ctl_hs_master`

## Requirements
- R1: Control word layout: bits 15:0 carry an address or data value, bit 16 is capture-address, bit 17 is capture-data, bit 18 is write, bit 19 is read. Every request starts the same way. The control word shows the address alone for one cycle, then the address with bit 16 set until ack (status bit 16) is seen high, then the address alone until ack is seen low.
- R2: A write continues with the data alone for one cycle, then the data with bit 17 until ack is high, then the data alone until ack is low. Next comes bit 18 alone (field zero) until ack is high, then the data alone until ack is low. After that the word is all zero and `done` pulses with `err` low.
- R3: A read continues with bit 19 alone (field zero) until ack is high. In that cycle status bits 15:0 are captured into `rdata`, and the word becomes all zero until ack is seen low. `done` then pulses with `err` low, and `rdata` holds its value until the next successful read.
- R4: At most one of control bits 19:16 is set in any cycle.
- R5: The control word does not change during a wait until the awaited ack level is seen or the wait times out.
- R6: A wait samples ack in its first cycle and then every POLL_CYCLES cycles, up to MAX_POLLS samples. A match on any sample, including the last one, ends the wait.
- R7: If the last sample does not match, `done` and `err` rise together one cycle later, the control word returns to zero and the block is idle. With the ack never rising, `done` appears 3 + POLL_CYCLES*(MAX_POLLS-1) cycles after the cycle in which the request is presented.
- R8: After a timeout the next request runs normally to completion.
- R9: `busy` is high from the cycle after a request is accepted until the cycle `done` pulses. `done` lasts exactly one cycle, and `err` is high only together with `done`.
- R10: A request presented while `busy` is high is ignored. No transaction starts from it and no PHY register changes.
- R11: After reset the control word is zero, and `busy`, `done`, `err` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when the block is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request ends |
| err | output | 1 | With `done`: the request ended on an ack timeout |
| rdata | output | 16 | Data returned by the last successful read |
| ctl_word | output | 20 | Control word to the PHY |
| stat_word | input | 17 | Status word from the PHY: bit 16 ack, bits 15:0 read data |

## Verification
The hardest situation to reach from the ports is the acknowledge that first becomes visible exactly on the last permitted sample, as opposed to one cycle too late. Stimulus gets there with a PHY model whose acknowledge latency is programmable. Latency 35 with 4-cycle spacing and 10 samples lands on the final sample, and latency 36 misses it, which also pins the exact cycle of the timeout `done`. A second hard case is a wait for ack low that never ends. The model's stuck-high acknowledge mode produces it, and a normal request afterwards shows that the block recovers.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

    localparam int unsigned FIELD_W      = 16;
    localparam int unsigned CTL_W        = 20;
    localparam int unsigned STAT_W       = 17;
    localparam int unsigned ACK_POS      = 16;

    // control word, most significant field first: read, write, cap-data, cap-addr, value
    typedef struct packed {
        logic               rd;
        logic               wr;
        logic               cap_data;
        logic               cap_addr;
        logic [FIELD_W-1:0] field;
    } ctl_word_t;

    typedef struct packed {
        logic               write;
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] wdata;
    } hs_req_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_SET,
        ST_A_CAP,
        ST_A_REL,
        ST_D_SET,
        ST_D_CAP,
        ST_D_REL,
        ST_W_STB,
        ST_W_REL,
        ST_R_STB,
        ST_R_REL
    } hs_state_e;

    typedef enum logic [1:0] {
        STB_CAP_ADDR,
        STB_CAP_DATA,
        STB_WRITE,
        STB_READ
    } hs_strobe_e;

    function automatic ctl_word_t value_word(input logic [FIELD_W-1:0] v);
        ctl_word_t w;
        w       = '0;
        w.field = v;
        return w;
    endfunction

    function automatic ctl_word_t strobe_word(input hs_strobe_e s, input logic [FIELD_W-1:0] v);
        ctl_word_t w;
        w = '0;
        case (s)
            STB_CAP_ADDR: begin w.cap_addr = 1'b1; w.field = v; end
            STB_CAP_DATA: begin w.cap_data = 1'b1; w.field = v; end
            STB_WRITE:    w.wr = 1'b1;
            default:      w.rd = 1'b1;
        endcase
        return w;
    endfunction

    function automatic logic is_wait(input hs_state_e s);
        case (s)
            ST_A_CAP, ST_A_REL, ST_D_CAP, ST_D_REL,
            ST_W_STB, ST_W_REL, ST_R_STB, ST_R_REL: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    // ack level awaited in a wait state: high after a strobe, low after a release
    function automatic logic wait_level(input hs_state_e s);
        case (s)
            ST_A_CAP, ST_D_CAP, ST_W_STB, ST_R_STB: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/phy_hs_ack_poller.sv
module phy_hs_ack_poller #(
    parameter int unsigned POLL_CYCLES = 200,
    parameter int unsigned MAX_POLLS   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_en,
    input  logic expect_lvl,
    input  logic ack,
    output logic hit,
    output logic timeout
);

    localparam int unsigned IVL_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int unsigned CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [IVL_W-1:0] IVL_LAST  = IVL_W'(POLL_CYCLES - 1);
    localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(MAX_POLLS - 1);

    logic [IVL_W-1:0] ivl_q;
    logic [CNT_W-1:0] polls_q;
    logic             poll_now;

    assign poll_now = wait_en && (ivl_q == '0);
    assign hit      = poll_now && (ack == expect_lvl);
    assign timeout  = poll_now && (ack != expect_lvl) && (polls_q == POLL_LAST);

    always_ff @(posedge clk) begin
        if (rst || !wait_en || hit || timeout) begin
            ivl_q   <= '0;
            polls_q <= '0;
        end else if (ivl_q == IVL_LAST) begin
            ivl_q   <= '0;
            polls_q <= polls_q + 1'b1;
        end else begin
            ivl_q   <= ivl_q + 1'b1;
        end
    end

    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        polls_q <= POLL_LAST);                                      // R6

    AST_WAIT_STARTS_FRESH: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_en) |-> (ivl_q == '0 && polls_q == '0));         // R6

endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
    import phy_hs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  hs_req_t            req_in,
    input  logic               hit,
    input  logic               timeout,
    input  logic [FIELD_W-1:0] stat_data,
    output logic               wait_en,
    output logic               expect_lvl,
    output ctl_word_t          ctl,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [FIELD_W-1:0] rdata
);

    hs_state_e          state_q;
    hs_req_t            req_q;
    ctl_word_t          ctl_q;
    logic               done_q;
    logic               err_q;
    logic [FIELD_W-1:0] rdata_q;

    assign wait_en    = is_wait(state_q);
    assign expect_lvl = wait_level(state_q);
    assign ctl        = ctl_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign rdata      = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            ctl_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (timeout) begin
                state_q <= ST_IDLE;
                ctl_q   <= '0;
                done_q  <= 1'b1;
                err_q   <= 1'b1;
            end else begin
                case (state_q)
                    ST_IDLE: if (req_valid) begin
                        req_q   <= req_in;
                        ctl_q   <= value_word(req_in.addr);
                        state_q <= ST_A_SET;
                    end
                    ST_A_SET: begin
                        ctl_q   <= strobe_word(STB_CAP_ADDR, req_q.addr);
                        state_q <= ST_A_CAP;
                    end
                    ST_A_CAP: if (hit) begin
                        ctl_q   <= value_word(req_q.addr);
                        state_q <= ST_A_REL;
                    end
                    ST_A_REL: if (hit) begin
                        if (req_q.write) begin
                            ctl_q   <= value_word(req_q.wdata);
                            state_q <= ST_D_SET;
                        end else begin
                            ctl_q   <= strobe_word(STB_READ, '0);
                            state_q <= ST_R_STB;
                        end
                    end
                    ST_D_SET: begin
                        ctl_q   <= strobe_word(STB_CAP_DATA, req_q.wdata);
                        state_q <= ST_D_CAP;
                    end
                    ST_D_CAP: if (hit) begin
                        ctl_q   <= value_word(req_q.wdata);
                        state_q <= ST_D_REL;
                    end
                    ST_D_REL: if (hit) begin
                        ctl_q   <= strobe_word(STB_WRITE, '0);
                        state_q <= ST_W_STB;
                    end
                    ST_W_STB: if (hit) begin
                        ctl_q   <= value_word(req_q.wdata);
                        state_q <= ST_W_REL;
                    end
                    ST_W_REL: if (hit) begin
                        ctl_q   <= '0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    ST_R_STB: if (hit) begin
                        rdata_q <= stat_data;
                        ctl_q   <= '0;
                        state_q <= ST_R_REL;
                    end
                    ST_R_REL: if (hit) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    default: begin
                        ctl_q   <= '0;
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({ctl_q.rd, ctl_q.wr, ctl_q.cap_data, ctl_q.cap_addr}) <= 1);   // R4

    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (wait_en && !hit && !timeout) |=> $stable(ctl_q));                         // R5

    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (done_q && err_q && ctl_q == '0 && state_q == ST_IDLE));       // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);                                                       // R9

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> done_q);                                                         // R9

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_A_SET));                           // R10

endmodule

// File: rtl/phy_ctl_hs_master.sv
module phy_ctl_hs_master
    import phy_hs_pkg::*;
#(
    parameter int unsigned POLL_CYCLES = 200,
    parameter int unsigned MAX_POLLS   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [FIELD_W-1:0] req_addr,
    input  logic [FIELD_W-1:0] req_wdata,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [FIELD_W-1:0] rdata,
    output logic [CTL_W-1:0]   ctl_word,
    input  logic [STAT_W-1:0]  stat_word
);

    hs_req_t   req_s;
    ctl_word_t ctl_s;
    logic      wait_en_s;
    logic      expect_s;
    logic      hit_s;
    logic      timeout_s;

    assign req_s    = '{write: req_write, addr: req_addr, wdata: req_wdata};
    assign ctl_word = ctl_s;

    phy_hs_ack_poller #(
        .POLL_CYCLES (POLL_CYCLES),
        .MAX_POLLS   (MAX_POLLS)
    ) poller_i (
        .clk        (clk),
        .rst        (rst),
        .wait_en    (wait_en_s),
        .expect_lvl (expect_s),
        .ack        (stat_word[ACK_POS]),
        .hit        (hit_s),
        .timeout    (timeout_s)
    );

    phy_hs_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_s),
        .hit        (hit_s),
        .timeout    (timeout_s),
        .stat_data  (stat_word[FIELD_W-1:0]),
        .wait_en    (wait_en_s),
        .expect_lvl (expect_s),
        .ctl        (ctl_s),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .rdata      (rdata)
    );

endmodule

// File: tb/phy_ctl_hs_master_tb.sv
module phy_ctl_hs_master_tb_top;

    localparam int POLL = 4;
    localparam int MAXP = 10;
    localparam int TMO_CYC = 3 + POLL * (MAXP - 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic [19:0] ctl_word;
    logic [16:0] stat_word;

    always #2.5 clk = ~clk;

    phy_ctl_hs_master #(.POLL_CYCLES(POLL), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .ctl_word(ctl_word), .stat_word(stat_word)
    );

    // ---------------- PHY model ----------------
    int          lat = 0;
    bit          stuck_high = 1'b0;
    logic        ack_q;
    int          cnt_q;
    logic [15:0] cap_addr_q, cap_data_q, rd_q;
    logic [15:0] phy_mem [16];
    logic        strobe_any;

    assign strobe_any = |ctl_word[19:16];
    assign stat_word  = {ack_q, rd_q};

    always @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0; cnt_q <= 0; cap_addr_q <= '0; cap_data_q <= '0; rd_q <= '0;
            for (int i = 0; i < 16; i++) phy_mem[i] <= '0;
        end else if (stuck_high) begin
            ack_q <= 1'b1;
            cnt_q <= 0;
        end else if (strobe_any != ack_q) begin
            if (cnt_q >= lat) begin
                ack_q <= strobe_any;
                cnt_q <= 0;
                if (strobe_any) begin
                    if (ctl_word[16]) cap_addr_q <= ctl_word[15:0];
                    if (ctl_word[17]) cap_data_q <= ctl_word[15:0];
                    if (ctl_word[18]) phy_mem[cap_addr_q[3:0]] <= cap_data_q;
                    if (ctl_word[19]) rd_q <= phy_mem[cap_addr_q[3:0]];
                end else begin
                    rd_q <= '0;
                end
            end else begin
                cnt_q <= cnt_q + 1;
            end
        end else begin
            cnt_q <= 0;
        end
    end

    // ---------------- monitors ----------------
    logic [19:0] log_q [$];
    logic [19:0] exp_q [$];
    logic [19:0] prev_ctl = '0;
    int          multi_strobe = 0;

    always @(posedge clk) begin
        if (ctl_word != prev_ctl) log_q.push_back(ctl_word);
        prev_ctl <= ctl_word;
        if (!rst && $countones(ctl_word[19:16]) > 1) multi_strobe++;
    end

    // ---------------- checking ----------------
    int checks = 0;
    int failures = 0;
    bit summary_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // expected control-word sequence from R1, R2, R3
    task automatic build_exp(input logic wr, input logic [15:0] a, input logic [15:0] d);
        exp_q.delete();
        exp_q.push_back({4'b0000, a});
        exp_q.push_back({4'b0001, a});
        exp_q.push_back({4'b0000, a});
        if (wr) begin
            exp_q.push_back({4'b0000, d});
            exp_q.push_back({4'b0010, d});
            exp_q.push_back({4'b0000, d});
            exp_q.push_back({4'b0100, 16'h0000});
            exp_q.push_back({4'b0000, d});
        end else begin
            exp_q.push_back({4'b1000, 16'h0000});
        end
        exp_q.push_back(20'h0);
    endtask

    function automatic bit log_matches();
        if (log_q.size() != exp_q.size()) return 1'b0;
        foreach (exp_q[i]) if (log_q[i] != exp_q[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_txn(input logic wr, input logic [15:0] a, input logic [15:0] d,
                           output int cyc, output logic e, output logic [15:0] rd,
                           output logic ctl_at_done);
        log_q.delete();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        e = err; rd = rdata; ctl_at_done = (ctl_word == '0);
        chk(busy == 1'b0, "R9", "busy at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R9", "done one cycle", {done, err}, 0);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  lat;
        logic [7:0]  cyc;
    } vec_t;

    // lat 35 puts the ack on the tenth sample (R6 boundary); cyc 0 = not checked
    localparam vec_t VECS [8] = '{
        '{1'b1, 16'h0012, 16'hBEEF, 8'd0,  8'd33},
        '{1'b1, 16'h0003, 16'h1234, 8'd5,  8'd0},
        '{1'b1, 16'hFFFF, 16'h0001, 8'd3,  8'd0},
        '{1'b0, 16'h0012, 16'hBEEF, 8'd0,  8'd22},
        '{1'b0, 16'h0003, 16'h1234, 8'd35, 8'd0},
        '{1'b0, 16'hFFFF, 16'h0001, 8'd1,  8'd0},
        '{1'b1, 16'h0003, 16'h00C3, 8'd35, 8'd0},
        '{1'b0, 16'h0003, 16'h00C3, 8'd2,  8'd0}
    };

    initial begin
        int          cyc;
        logic        e, cz;
        logic [15:0] rd;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(ctl_word == '0, "R11", "ctl after reset", ctl_word, 0);
        chk({busy, done, err} == 3'b000, "R11", "busy/done/err after reset", {busy, done, err}, 0);
        chk(rdata == '0, "R11", "rdata after reset", rdata, 0);

        // table walk: R1 R2 R3 R5 R6
        foreach (VECS[i]) begin
            lat = int'(VECS[i].lat);
            build_exp(VECS[i].wr, VECS[i].addr, VECS[i].data);
            run_txn(VECS[i].wr, VECS[i].addr, VECS[i].data, cyc, e, rd, cz);
            chk(e == 1'b0, "R6", $sformatf("vec %0d err", i), e, 0);
            chk(cz, "R2 R3", $sformatf("vec %0d ctl zero at done", i), ctl_word, 0);
            chk(log_matches(), "R1 R2 R3 R5", $sformatf("vec %0d word sequence len", i),
                log_q.size(), exp_q.size());
            if (VECS[i].wr)
                chk(phy_mem[VECS[i].addr[3:0]] == VECS[i].data, "R2",
                    $sformatf("vec %0d PHY reg", i), phy_mem[VECS[i].addr[3:0]], VECS[i].data);
            else
                chk(rd == VECS[i].data, "R3", $sformatf("vec %0d rdata", i), rd, VECS[i].data);
            if (VECS[i].cyc != 0)
                chk(cyc == int'(VECS[i].cyc), "R6", $sformatf("vec %0d cycles", i),
                    cyc, VECS[i].cyc);
        end
        // R3: rdata held through a write
        lat = 1;
        run_txn(1'b1, 16'h0005, 16'h7777, cyc, e, rd, cz);
        chk(rdata == 16'h00C3, "R3", "rdata held after write", rdata, 16'h00C3);

        // R7: ack one cycle past the last sample -> timeout
        lat = 36;
        run_txn(1'b1, 16'h0007, 16'h4444, cyc, e, rd, cz);
        chk(e == 1'b1, "R7", "timeout err", e, 1);
        chk(cyc == TMO_CYC, "R7", "timeout done cycle", cyc, TMO_CYC);
        chk(cz, "R7", "ctl zero after timeout", ctl_word, 0);
        chk(phy_mem[7] == 16'h0000, "R7", "no write on timeout", phy_mem[7], 0);

        // R8: recovery after timeout
        lat = 2;
        build_exp(1'b0, 16'h0012, 16'h0);
        run_txn(1'b0, 16'h0012, 16'h0, cyc, e, rd, cz);
        chk(e == 1'b0 && rd == 16'hBEEF, "R8", "read after timeout", {e, rd}, 17'h0BEEF);

        // R7: ack stuck high -> the wait for ack low times out
        stuck_high = 1'b1;
        repeat (2) @(negedge clk);
        run_txn(1'b1, 16'h0008, 16'h2222, cyc, e, rd, cz);
        chk(e == 1'b1, "R7", "stuck ack err", e, 1);
        chk(cz, "R7", "ctl zero after stuck ack", ctl_word, 0);
        stuck_high = 1'b0;
        repeat (10) @(negedge clk);
        lat = 0;
        run_txn(1'b1, 16'h0009, 16'h3333, cyc, e, rd, cz);
        chk(e == 1'b0 && phy_mem[9] == 16'h3333, "R8", "write after stuck ack",
            phy_mem[9], 16'h3333);

        // R10: request while busy is ignored
        lat = 3;
        build_exp(1'b1, 16'h000A, 16'hA5A5);
        log_q.delete();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h000A; req_wdata = 16'hA5A5;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h000B; req_wdata = 16'h5A5A;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        repeat (12) begin
            @(negedge clk);
            if (busy) cyc = 5000;
        end
        chk(cyc < 2000, "R10", "no second transaction", cyc, 0);
        chk(phy_mem[11] == 16'h0000, "R10", "ignored request left reg", phy_mem[11], 0);
        chk(phy_mem[10] == 16'hA5A5, "R10", "first request completed", phy_mem[10], 16'hA5A5);
        chk(log_matches(), "R10", "word sequence len", log_q.size(), exp_q.size());

        chk(multi_strobe == 0, "R4", "cycles with several strobes", multi_strobe, 0);

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

endmodule